// File: doc/BRIEF.md
# GPIO Port Pin Interrupt Detector

This block watches the input pins of a GPIO port and turns selected pin activity into one interrupt line for a processor. Each pin has its own trigger settings. It can sense edges or levels. Edge sensing can fire on one edge of a chosen direction or on both edges. Level sensing fires on a chosen level. A mask decides whether the pin may drive the shared interrupt line.

The pins are first passed through a two-flop synchroniser. Edge events set sticky per-pin status bits, and software acknowledges them by writing ones to a clear register. A level-sensed pin's status follows the synchronised pin. The masked status is the raw status gated by the mask. The OR of the masked status is registered onto the interrupt output.

All registers sit on a plain single-cycle register bus. Read data is registered and is valid one cycle after the request. A parameter states which port bits are wired to pads. Bits that are not wired ignore writes, read as zero and can never raise an interrupt.

Top module: `gpio_irq_unit`

## Requirements
- R1: After a synchronous reset every configuration and status register reads 0 and `irq_o` is low. This means every pin is masked and set for single falling-edge sensing.
- R2: For a pin with sense=0, both=0, event=1 and mask=1, and all other pins masked, only a rising edge on that pin raises `irq_o`. A falling edge does not.
- R3: With sense=0, both=0 and event=0, only a falling edge sets the pin's raw status.
- R4: With sense=0 and both=1, both rising and falling edges set raw status, whatever the event bit holds.
- R5: With sense=1, the pin's raw status is 1 while the synchronised pin equals its event bit (1 = high, 0 = low) and 0 otherwise. Clear writes do not change it.
- R6: An edge-sensed raw status bit stays set until a 1 is written to that bit of the clear register. Writing 0 to a clear bit leaves that bit unchanged.
- R7: If an edge event and a clear write for the same bit reach the status bit in the same cycle, the bit stays set.
- R8: Masked status equals raw status AND mask. `irq_o` is the OR of the masked-status bits, registered, so it follows one cycle after the raw status changes.
- R9: For port bits that are 0 in `PIN_CONN`, writes are ignored, every register bit reads 0, and the pin never sets status or interrupts.
- R10: Register addresses are: 0 sense, 1 both-edges, 2 event, 3 mask, 4 raw status (read-only), 5 masked status (read-only), 6 clear (write-only, reads 0). A read issued in one cycle returns its data on `bus_rdata` after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NPINS | Asynchronous pin levels |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Registered read data |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
Some properties are checked by the bound assertions on every cycle. These are that `irq_o` tracks the registered OR of raw status and mask, and that a detected edge always lands in raw status even when a clear arrives at the same time. They also cover that edge status holds until it is cleared, that unwired bits never hold configuration, and the reset state. Other behaviour can only be shown by the bench's scenarios. These are which pin transitions count as events under each trigger setting, that level pins ignore clears, and the register address decode and readback. The bench also lines up a pin edge with a clear write to hit the same-cycle case exactly, and one cycle later to show the clear wins then.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_SENSE  = 3'd0,
    A_BOTH   = 3'd1,
    A_EVENT  = 3'd2,
    A_MASK   = 3'd3,
    A_RAW    = 3'd4,
    A_MSKST  = 3'd5,
    A_CLEAR  = 3'd6,
    A_SPARE  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;
  logic [W-1:0] cur_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin (
  input  logic clk,
  input  logic rst,
  input  logic cur,
  input  logic prev,
  input  logic sense,
  input  logic both,
  input  logic evsel,
  input  logic clr,
  output logic hit,
  output logic raw
);
  logic rise;
  logic fall;
  logic lvl;
  logic raw_q;

  assign rise = cur & ~prev;
  assign fall = ~cur & prev;
  assign lvl  = evsel ? cur : ~cur;

  always_comb begin
    if (sense)      hit = 1'b0;
    else if (both)  hit = rise | fall;
    else if (evsel) hit = rise;
    else            hit = fall;
  end

  always_ff @(posedge clk) begin
    if (rst)        raw_q <= 1'b0;
    else if (sense) raw_q <= lvl;
    else            raw_q <= hit | (raw_q & ~clr);
  end

  assign raw = raw_q;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int               NPINS = 8,
  parameter logic [NPINS-1:0] CONN  = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  raw,
  output logic [NPINS-1:0]  sense,
  output logic [NPINS-1:0]  both,
  output logic [NPINS-1:0]  evsel,
  output logic [NPINS-1:0]  mask,
  output logic [NPINS-1:0]  clr
);
  reg_addr_e          addr;
  logic               do_wr;
  logic               do_rd;
  logic [NPINS-1:0]   wval;
  logic [NPINS-1:0]   sense_q, both_q, evsel_q, mask_q;
  logic [NPINS-1:0]   rmux;
  logic [NPINS-1:0]   rdata_q;

  assign addr  = reg_addr_e'(bus_addr);
  assign do_wr = bus_sel & bus_wr;
  assign do_rd = bus_sel & ~bus_wr;
  assign wval  = bus_wdata & CONN;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= '0;
      both_q  <= '0;
      evsel_q <= '0;
      mask_q  <= '0;
    end else if (do_wr) begin
      case (addr)
        A_SENSE: sense_q <= wval;
        A_BOTH:  both_q  <= wval;
        A_EVENT: evsel_q <= wval;
        A_MASK:  mask_q  <= wval;
        default: ;
      endcase
    end
  end

  assign clr = (do_wr && addr == A_CLEAR) ? wval : '0;

  always_comb begin
    case (addr)
      A_SENSE: rmux = sense_q;
      A_BOTH:  rmux = both_q;
      A_EVENT: rmux = evsel_q;
      A_MASK:  rmux = mask_q;
      A_RAW:   rmux = raw & CONN;
      A_MSKST: rmux = raw & mask_q & CONN;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (do_rd) rdata_q <= rmux;
  end

  assign bus_rdata = rdata_q;
  assign sense     = sense_q;
  assign both      = both_q;
  assign evsel     = evsel_q;
  assign mask      = mask_q;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int               NPINS    = 8,
  parameter logic [NPINS-1:0] PIN_CONN = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pins_i,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  output logic             irq_o
);
  logic [NPINS-1:0] cur, prev;
  logic [NPINS-1:0] sense_q, both_q, evsel_q, mask_q;
  logic [NPINS-1:0] clr_bits;
  logic [NPINS-1:0] raw_q;
  logic [NPINS-1:0] edge_hit;
  logic             irq_q;

  gpio_irq_sync #(.W(NPINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pins_i),
    .cur (cur),
    .prev(prev)
  );

  gpio_irq_regs #(.NPINS(NPINS), .CONN(PIN_CONN)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .raw      (raw_q),
    .sense    (sense_q),
    .both     (both_q),
    .evsel    (evsel_q),
    .mask     (mask_q),
    .clr      (clr_bits)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    if (PIN_CONN[i]) begin : g_wired
      gpio_irq_pin u_pin (
        .clk  (clk),
        .rst  (rst),
        .cur  (cur[i]),
        .prev (prev[i]),
        .sense(sense_q[i]),
        .both (both_q[i]),
        .evsel(evsel_q[i]),
        .clr  (clr_bits[i]),
        .hit  (edge_hit[i]),
        .raw  (raw_q[i])
      );
    end else begin : g_open
      assign edge_hit[i] = 1'b0;
      assign raw_q[i]    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(raw_q & mask_q);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int               NPINS = 8,
  parameter logic [NPINS-1:0] CONN  = '1
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_o,
  input logic [NPINS-1:0] raw_q,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] sense_q,
  input logic [NPINS-1:0] edge_hit,
  input logic [NPINS-1:0] clr_bits
);
  // R1: first cycle out of reset shows cleared status and quiet interrupt
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (raw_q == '0 && mask_q == '0 && !irq_o));

  // R8: interrupt output is the registered OR of masked status
  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|(raw_q & mask_q))));

  // R7: a detected edge always lands in raw status, even against a clear
  assert_event_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (edge_hit != '0) |=> ((raw_q & $past(edge_hit)) == $past(edge_hit)));

  // R6: edge status holds while no clear bit is written for it
  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(raw_q & ~sense_q & ~clr_bits) & ~sense_q & ~raw_q) == '0));

  // R9: unwired bits never carry configuration or status
  assert_unwired_R9: assert property (@(posedge clk) disable iff (rst)
    (((mask_q | sense_q | raw_q) & ~CONN) == '0));
endmodule

bind gpio_irq_unit gpio_irq_chk #(.NPINS(NPINS), .CONN(PIN_CONN)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .irq_o   (irq_o),
  .raw_q   (raw_q),
  .mask_q  (mask_q),
  .sense_q (sense_q),
  .edge_hit(edge_hit),
  .clr_bits(clr_bits)
);

// File: tb/sim_gpio_irq_unit.sv
`timescale 1ns/1ps
module sim_gpio_irq_unit;
  localparam logic [7:0] CONN = 8'hBF;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pins = '0;
  logic       sel = 1'b0, wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] cs = '0, cb = '0, ce = '0, cm = '0, pv = '0, er = '0;
  logic [7:0] rd;

  always #5 clk = ~clk;

  gpio_irq_unit #(.NPINS(8), .PIN_CONN(CONN)) u0 (
    .clk(clk), .rst(rst), .pins_i(pins), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] hits(input logic [7:0] o, input logic [7:0] n);
    logic [7:0] r, f;
    r = n & ~o;
    f = ~n & o;
    return ((cb & (r | f)) | (~cb & ce & r) | (~cb & ~ce & f)) & ~cs & CONN;
  endfunction

  task automatic bus_write(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = v;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_read(input logic [2:0] a);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    @(negedge clk); sel = 0;
    rd = rdata;
  endtask

  task automatic settle_check(input string tag);
    repeat (6) @(negedge clk);
    er = ((er & ~cs) | (cs & ~(pv ^ ce))) & CONN;
    bus_read(3'd4); check({tag, " raw"}, rd, er);
    bus_read(3'd5); check({tag, " masked R8"}, rd, er & cm);
    check({tag, " irq R8"}, {7'd0, irq}, {7'd0, |(er & cm)});
  endtask

  task automatic set_pins(input logic [7:0] nv, input string tag);
    @(negedge clk); pins = nv;
    er |= hits(pv, nv);
    pv = nv;
    settle_check(tag);
  endtask

  task automatic clear(input logic [7:0] v);
    bus_write(3'd6, v);
    er &= ~(v & ~cs & CONN);
  endtask

  task automatic config_all(input logic [7:0] s, b, e, m);
    bus_write(3'd0, s); cs = s & CONN;
    bus_write(3'd1, b); cb = b & CONN;
    bus_write(3'd2, e); ce = e & CONN;
    bus_write(3'd3, m); cm = m & CONN;
    bus_write(3'd6, 8'hFF);
    er = '0;
    settle_check("config");
  endtask

  // pin 2 rising with a clear write reaching the status bit d cycles after the pin change
  task automatic race(input int d, input logic exp);
    @(negedge clk); pins[2] = 1'b1;
    repeat (d) @(negedge clk);
    sel = 1; wr = 1; addr = 3'd6; wdata = 8'h04;
    @(negedge clk); sel = 0; wr = 0;
    repeat (4) @(negedge clk);
    bus_read(3'd4);
    check($sformatf("R7 race d=%0d", d), rd & 8'h04, exp ? 8'h04 : 8'h00);
    @(negedge clk); pins[2] = 1'b0;
    repeat (6) @(negedge clk);
    bus_write(3'd6, 8'hFF);
    pv = pins;
    er = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      bus_read(a[2:0]);
      check($sformatf("R1 reg %0d", a), rd, 8'h00);
    end
    check("R1 irq", {7'd0, irq}, 8'h00);

    // R10 readback and address map
    bus_write(3'd0, 8'h5A); bus_read(3'd0); check("R10 sense rb", rd, 8'h5A & CONN);
    bus_write(3'd2, 8'hC3); bus_read(3'd2); check("R10 event rb", rd, 8'hC3 & CONN);
    bus_read(3'd6); check("R10 clear reads 0", rd, 8'h00);
    bus_write(3'd0, 8'h00); bus_write(3'd2, 8'h00);

    // R2 rising only on pin 2, others masked
    config_all(8'h00, 8'h00, 8'h04, 8'h04);
    set_pins(8'h04, "R2 rise");
    check("R2 irq on rise", {7'd0, irq}, 8'h01);
    clear(8'h04); settle_check("R6 clear");
    set_pins(8'h00, "R2 fall");
    check("R2 no irq on fall", {7'd0, irq}, 8'h00);
    set_pins(8'h01, "R2 other pin");
    check("R2 other pin masked", {7'd0, irq}, 8'h00);
    set_pins(8'h00, "R2 restore");

    // R7 same-cycle race, then clear one cycle late wins
    clear(8'hFF);
    race(2, 1'b1);
    race(3, 1'b0);

    // R3 falling only
    config_all(8'h00, 8'h00, 8'h00, 8'hFF);
    set_pins(8'h08, "R3 rise ignored");
    set_pins(8'h00, "R3 fall sets");
    clear(8'h00); settle_check("R6 clear zero no effect");

    // R4 both edges, event bit ignored
    config_all(8'h00, 8'hFF, 8'hAA, 8'hFF);
    set_pins(8'h11, "R4 rise");
    clear(8'hFF); settle_check("R4 cleared");
    set_pins(8'h00, "R4 fall");

    // R5 level sensing, clear ignored
    config_all(8'hFF, 8'h00, 8'h0F, 8'hFF);
    set_pins(8'h05, "R5 level");
    clear(8'hFF); settle_check("R5 clear ignored");
    set_pins(8'hF0, "R5 level change");

    // R9 unwired pin 6
    config_all(8'h00, 8'hFF, 8'h00, 8'hFF);
    bus_read(3'd3); check("R9 mask unwired", rd, 8'hBF);
    set_pins(8'h40, "R9 pin6 toggle");
    check("R9 pin6 raw", rd & 8'h40, 8'h00);
    set_pins(8'h00, "R9 pin6 back");

    // constrained random mix
    for (int it = 0; it < 60; it++) begin
      int op;
      op = $urandom % 4;
      if (op == 0) config_all($urandom, $urandom, $urandom, $urandom);
      else if (op == 3) begin clear($urandom); settle_check("rand clear R6"); end
      else set_pins($urandom, "rand pins R2-R5");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule